// File: doc/BRIEF.md
# Cycle-Stealing DMA Controller

This block is a single-channel direct memory access engine that moves a block of words between one peripheral and system memory. Software loads four values through a small register window: the transfer direction, the device number, the first memory address and the word count. A start command then begins the transfer, and the processor carries on with other work. The engine sits on the system bus itself, so each word crosses that bus exactly once, going straight between the device port and memory.

The engine never holds the bus for a burst. For each word it first waits until the device reports that it can take part: it has data for an input transfer, or room for an output transfer. It then raises a bus request and keeps it raised until the arbiter grants. It moves one word in the granted cycle and drops the request at once. The processor is held off for that one cycle only and does not switch context. After each word the memory address moves forward by one word and the remaining count falls by one. When the count reaches zero, a completion flag drives the interrupt line. The flag stays set until software reads the status word or issues a new start.

Top module: `cs_dma`

## Requirements
- R1: After a synchronous active-high reset, `bus_req`, `mem_en`, `dev_ack` and `irq` are low, and all four register slots read back zero.
- R2: While the engine is idle, software can write these slots and read them back on `cfg_rdata` in the same cycle as the read: slot 1 holds the device number (low DEV_W bits), slot 2 holds the memory address and slot 3 holds the word count. Slot 0 reads as status, with bit 0 busy, bit 1 direction and bit 2 done.
- R3: After a start, the engine raises `bus_req` only in the cycle after a cycle in which `dev_rdy` was sampled high.
- R4: Once raised, `bus_req` stays high until `bus_gnt` is high. A word moves (`mem_en` and `dev_ack` high) only in a cycle where both `bus_req` and `bus_gnt` are high. A `bus_gnt` without a request has no effect.
- R5: In the cycle after each word moves, `bus_req` is low.
- R6: Slot 0 write bit 1 sets the direction. With 0 (input), each word is written to memory (`mem_we` high, `mem_wdata` equal to `dev_rdata`). With 1 (output), memory is read (`mem_we` low) and `dev_wdata` carries `mem_rdata`.
- R7: Each moved word adds ADDR_STEP to the address and subtracts one from the count. Both can be read back.
- R8: In the second cycle after the last word moves, `irq` goes high and the status busy bit reads zero.
- R9: A start (slot 0 write with bit 0 set) issued with a count of zero sets `irq` in the next cycle and never raises `bus_req`.
- R10: `irq` stays high until a status read (a read of slot 0) or an accepted start clears it. If completion and a clear happen in the same cycle, completion wins.
- R11: While busy, writes to any slot, including a second start, are ignored.
- R12: `dev_id` always presents the stored device number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_rd | input | 1 | Register read strobe (needed to clear on status read) |
| cfg_sel | input | 2 | Register slot: 0 control/status, 1 device, 2 address, 3 count |
| cfg_wdata | input | DATA_W | Register write data |
| cfg_rdata | output | DATA_W | Read-back of the selected slot |
| irq | output | 1 | Completion interrupt |
| bus_req | output | 1 | System bus request |
| bus_gnt | input | 1 | System bus grant |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Memory write (input direction) |
| mem_addr | output | DATA_W | Current memory address |
| mem_wdata | output | DATA_W | Data written to memory |
| mem_rdata | input | DATA_W | Data read from memory |
| dev_id | output | DEV_W | Selected device number |
| dev_rdy | input | 1 | Device has data or space |
| dev_ack | output | 1 | Word taken from or given to the device |
| dev_wdata | output | DATA_W | Data sent to the device |
| dev_rdata | input | DATA_W | Data offered by the device |

## Verification
Most internal faults in this engine appear at the ports within one or two cycles. A wrong sequencer state shows as a missing or extra `bus_req`, or as a transfer strobe without grant in the very next cycle. A wrong address or count shows on `mem_addr` during the next granted word, and on the readback as soon as software looks. A completion flag that is lost, set too early or cleared wrongly shows directly on `irq`. A cycle-accurate model in the bench is compared with every output on every clock, so such a divergence is reported in the cycle it first becomes visible.

// File: rtl/dma_pkg.sv
package dma_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_WAIT = 2'd1,
        SEQ_REQ  = 2'd2,
        SEQ_GAP  = 2'd3
    } seq_state_t;

    typedef enum logic [1:0] {
        SLOT_CTRL = 2'd0,
        SLOT_DEV  = 2'd1,
        SLOT_ADDR = 2'd2,
        SLOT_CNT  = 2'd3
    } cfg_slot_t;

    localparam int CTRL_GO_BIT  = 0;
    localparam int CTRL_DIR_BIT = 1;
    localparam int STAT_BUSY    = 0;
    localparam int STAT_DIR     = 1;
    localparam int STAT_DONE    = 2;

    // Decoded register-window actions for one cycle
    typedef struct packed {
        logic go;
        logic wr_dir;
        logic wr_dev;
        logic wr_addr;
        logic wr_cnt;
        logic rd_stat;
    } cfg_cmd_t;

    function automatic logic [2:0] pack_status(input logic busy, input logic dir, input logic done);
        logic [2:0] s;
        s = '0;
        s[STAT_BUSY] = busy;
        s[STAT_DIR]  = dir;
        s[STAT_DONE] = done;
        return s;
    endfunction

endpackage

// File: rtl/dma_cfg_decode.sv
module dma_cfg_decode
    import dma_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              cfg_wr,
    input  logic              cfg_rd,
    input  logic [1:0]        cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              busy,
    output cfg_cmd_t          cmd
);

    cfg_slot_t slot;
    logic      wr_ok;

    always_comb begin
        slot  = cfg_slot_t'(cfg_sel);
        wr_ok = cfg_wr && !busy;
        cmd.wr_dir  = wr_ok && (slot == SLOT_CTRL);
        cmd.go      = wr_ok && (slot == SLOT_CTRL) && cfg_wdata[CTRL_GO_BIT];
        cmd.wr_dev  = wr_ok && (slot == SLOT_DEV);
        cmd.wr_addr = wr_ok && (slot == SLOT_ADDR);
        cmd.wr_cnt  = wr_ok && (slot == SLOT_CNT);
        cmd.rd_stat = cfg_rd && (slot == SLOT_CTRL);
    end

endmodule

// File: rtl/dma_regs.sv
module dma_regs
    import dma_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int DEV_W     = 4,
    parameter int ADDR_STEP = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  cfg_cmd_t          cmd,
    input  logic [DATA_W-1:0] wdata,
    input  logic              step,
    input  logic              done_set,
    output logic              dir,
    output logic [DEV_W-1:0]  dev,
    output logic [DATA_W-1:0] addr,
    output logic [DATA_W-1:0] cnt,
    output logic              done,
    output logic              cnt_zero
);

    localparam logic [DATA_W-1:0] STEP_V = DATA_W'(ADDR_STEP);
    localparam logic [DATA_W-1:0] ONE_V  = DATA_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            dir  <= 1'b0;
            dev  <= '0;
            addr <= '0;
            cnt  <= '0;
            done <= 1'b0;
        end else begin
            if (cmd.wr_dir) dir <= wdata[CTRL_DIR_BIT];
            if (cmd.wr_dev) dev <= wdata[DEV_W-1:0];
            if (cmd.wr_addr)  addr <= wdata;
            else if (step)    addr <= addr + STEP_V;
            if (cmd.wr_cnt)   cnt <= wdata;
            else if (step)    cnt <= cnt - ONE_V;
            if (done_set)                     done <= 1'b1;
            else if (cmd.rd_stat || cmd.go)   done <= 1'b0;
        end
    end

    assign cnt_zero = (cnt == '0);

    assert_count_dec_R7: assert property (@(posedge clk) disable iff (rst)
        step |=> (cnt == $past(cnt) - ONE_V));
    assert_addr_inc_R7: assert property (@(posedge clk) disable iff (rst)
        step |=> (addr == $past(addr) + STEP_V));
    assert_done_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (done && !cmd.rd_stat && !cmd.go) |=> done);

endmodule

// File: rtl/dma_seq.sv
module dma_seq
    import dma_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic go,
    input  logic cnt_zero,
    input  logic dev_rdy,
    input  logic bus_gnt,
    output logic bus_req,
    output logic xfer,
    output logic done_set,
    output logic busy
);

    seq_state_t state, state_nx;

    always_comb begin
        state_nx = state;
        done_set = 1'b0;
        unique case (state)
            SEQ_IDLE: if (go) begin
                if (cnt_zero) done_set = 1'b1;
                else          state_nx = SEQ_WAIT;
            end
            SEQ_WAIT: if (dev_rdy) state_nx = SEQ_REQ;
            SEQ_REQ:  if (bus_gnt) state_nx = SEQ_GAP;
            SEQ_GAP: begin
                if (cnt_zero) begin
                    done_set = 1'b1;
                    state_nx = SEQ_IDLE;
                end else begin
                    state_nx = SEQ_WAIT;
                end
            end
            default: state_nx = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= SEQ_IDLE;
        else     state <= state_nx;
    end

    assign bus_req = (state == SEQ_REQ);
    assign xfer    = bus_req && bus_gnt;
    assign busy    = (state != SEQ_IDLE);

    assert_hold_req_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_gnt) |=> bus_req);
    assert_release_R5: assert property (@(posedge clk) disable iff (rst)
        xfer |=> !bus_req);
    assert_rdy_first_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_req) |-> $past(dev_rdy));

endmodule

// File: rtl/cs_dma.sv
module cs_dma
    import dma_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int DEV_W     = 4,
    parameter int ADDR_STEP = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic              cfg_rd,
    input  logic [1:0]        cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    output logic              irq,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              mem_en,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DEV_W-1:0]  dev_id,
    input  logic              dev_rdy,
    output logic              dev_ack,
    output logic [DATA_W-1:0] dev_wdata,
    input  logic [DATA_W-1:0] dev_rdata
);

    cfg_cmd_t          cmd;
    logic              busy, xfer, done_set, cnt_zero, dir, done;
    logic [DEV_W-1:0]  dev;
    logic [DATA_W-1:0] addr, cnt, dev_ext, stat_ext;

    dma_cfg_decode #(.DATA_W(DATA_W)) u_dec (
        .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .busy(busy), .cmd(cmd)
    );

    dma_regs #(.DATA_W(DATA_W), .DEV_W(DEV_W), .ADDR_STEP(ADDR_STEP)) u_regs (
        .clk(clk), .rst(rst), .cmd(cmd), .wdata(cfg_wdata), .step(xfer),
        .done_set(done_set), .dir(dir), .dev(dev), .addr(addr), .cnt(cnt),
        .done(done), .cnt_zero(cnt_zero)
    );

    dma_seq u_seq (
        .clk(clk), .rst(rst), .go(cmd.go), .cnt_zero(cnt_zero),
        .dev_rdy(dev_rdy), .bus_gnt(bus_gnt), .bus_req(bus_req),
        .xfer(xfer), .done_set(done_set), .busy(busy)
    );

    generate
        if (DEV_W < DATA_W) begin : g_dev_pad
            assign dev_ext = {{(DATA_W-DEV_W){1'b0}}, dev};
        end else begin : g_dev_full
            assign dev_ext = dev[DATA_W-1:0];
        end
    endgenerate

    assign stat_ext = {{(DATA_W-3){1'b0}}, pack_status(busy, dir, done)};

    always_comb begin
        unique case (cfg_slot_t'(cfg_sel))
            SLOT_CTRL: cfg_rdata = stat_ext;
            SLOT_DEV:  cfg_rdata = dev_ext;
            SLOT_ADDR: cfg_rdata = addr;
            SLOT_CNT:  cfg_rdata = cnt;
            default:   cfg_rdata = '0;
        endcase
    end

    assign irq       = done;
    assign mem_en    = xfer;
    assign mem_we    = xfer && !dir;
    assign mem_addr  = addr;
    assign mem_wdata = dev_rdata;
    assign dev_ack   = xfer;
    assign dev_wdata = mem_rdata;
    assign dev_id    = dev;

    assert_zero_done_R9: assert property (@(posedge clk) disable iff (rst)
        (cmd.go && cnt_zero) |=> (irq && !bus_req));
    assert_locked_dev_R11: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && busy && cfg_sel == 2'd1) |=> $stable(dev_id));
    assert_locked_cnt_R11: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && busy && !mem_en && cfg_sel == 2'd3) |=> $stable(cnt));
    assert_xfer_nonzero_R7: assert property (@(posedge clk) disable iff (rst)
        mem_en |-> (cnt != '0));

endmodule

// File: tb/sim_cs_dma.sv
module sim_cs_dma;
    localparam int PERIOD = 10;
    localparam int DW = 16;

    logic clk = 0, rst = 1;
    logic cfg_wr = 0, cfg_rd = 0;
    logic [1:0] cfg_sel = 0;
    logic [DW-1:0] cfg_wdata = 0, cfg_rdata;
    logic irq, bus_req, bus_gnt = 0, mem_en, mem_we, dev_rdy = 0, dev_ack;
    logic [DW-1:0] mem_addr, mem_wdata, mem_rdata, dev_wdata, dev_rdata;
    logic [3:0] dev_id;

    int checks = 0, errors = 0, cyc = 0;
    bit seen_edge = 0;

    logic [DW-1:0] mem [0:255];
    logic [DW-1:0] dev_seq;
    logic [DW-1:0] dev_got [$];

    // stimulus knobs
    int gnt_lat = 0;
    bit gnt_spur = 0;
    int rdy_mode = 1;
    int hold = 0;

    // reference model
    int ms = 0;
    bit m_dir = 0, m_done = 0;
    logic [3:0] m_dev = 0;
    logic [DW-1:0] m_addr = 0, m_cnt = 0;

    assign mem_rdata = mem[mem_addr[7:0]];
    assign dev_rdata = dev_seq;

    cs_dma u0 (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq(irq), .bus_req(bus_req),
        .bus_gnt(bus_gnt), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .dev_id(dev_id), .dev_rdy(dev_rdy),
        .dev_ack(dev_ack), .dev_wdata(dev_wdata), .dev_rdata(dev_rdata)
    );

    always #(PERIOD/2) clk = ~clk;
    always @(posedge clk) begin cyc <= cyc + 1; seen_edge <= 1'b1; end

    task automatic cmp(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    // bus arbiter and device behaviour, driven at the falling edge
    always @(negedge clk) begin
        if (bus_req) begin
            bus_gnt = (hold >= gnt_lat);
            hold++;
        end else begin
            hold = 0;
            bus_gnt = gnt_spur;
        end
        if (rdy_mode == 0)      dev_rdy = 1'b0;
        else if (rdy_mode == 1) dev_rdy = 1'b1;
        else                    dev_rdy = ((cyc % rdy_mode) == 0);
    end

    // per-cycle comparison with the reference model, then model advance
    always @(negedge clk) begin
        bit busy_m, go_m, x_m, set_m;
        logic [DW-1:0] exp_rd;
        #1;
        busy_m = (ms != 0);
        x_m    = (ms == 2) && bus_gnt;
        if (seen_edge && !rst) begin
            cmp("R3/R4/R5", "bus_req", bus_req, (ms == 2));
            cmp("R4", "mem_en", mem_en, x_m);
            cmp("R4", "dev_ack", dev_ack, x_m);
            cmp("R6", "mem_we", mem_we, x_m && !m_dir);
            cmp("R8/R9/R10", "irq", irq, m_done);
            cmp("R12", "dev_id", dev_id, m_dev);
            if (x_m) cmp("R7", "mem_addr", mem_addr, m_addr);
            if (x_m && !m_dir) cmp("R6", "mem_wdata", mem_wdata, dev_rdata);
            if (x_m && m_dir)  cmp("R6", "dev_wdata", dev_wdata, mem_rdata);
            case (cfg_sel)
                2'd0: exp_rd = {13'd0, m_done, m_dir, busy_m};
                2'd1: exp_rd = {12'd0, m_dev};
                2'd2: exp_rd = m_addr;
                default: exp_rd = m_cnt;
            endcase
            cmp("R2", "cfg_rdata", cfg_rdata, exp_rd);
        end
        // bench-side memory and device effects of this cycle's transfer
        if (rst) begin
            for (int i = 0; i < 256; i++) mem[i] = DW'(i * 3 + 7);
            dev_seq = 16'hA000;
            dev_got.delete();
        end else if (mem_en) begin
            if (mem_we) begin
                mem[mem_addr[7:0]] = mem_wdata;
                dev_seq = dev_seq + 1'b1;
            end else begin
                dev_got.push_back(dev_wdata);
            end
        end
        // model next state
        go_m = cfg_wr && cfg_sel == 2'd0 && cfg_wdata[0] && !busy_m;
        if (rst) begin
            ms = 0; m_dir = 0; m_done = 0; m_dev = 0; m_addr = 0; m_cnt = 0;
        end else begin
            set_m = 0;
            case (ms)
                0: if (go_m) begin if (m_cnt == 0) set_m = 1; else ms = 1; end
                1: if (dev_rdy) ms = 2;
                2: if (bus_gnt) begin ms = 3; m_addr = m_addr + 1'b1; m_cnt = m_cnt - 1'b1; end
                default: begin if (m_cnt == 0) begin set_m = 1; ms = 0; end else ms = 1; end
            endcase
            if (cfg_wr && !busy_m) begin
                case (cfg_sel)
                    2'd0: m_dir = cfg_wdata[1];
                    2'd1: m_dev = cfg_wdata[3:0];
                    2'd2: m_addr = cfg_wdata;
                    default: m_cnt = cfg_wdata;
                endcase
            end
            if (set_m) m_done = 1;
            else if ((cfg_rd && cfg_sel == 2'd0) || go_m) m_done = 0;
        end
    end

    task automatic wr(input logic [1:0] sel, input logic [DW-1:0] d);
        @(negedge clk); cfg_wr = 1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk); cfg_wr = 0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [DW-1:0] v);
        @(negedge clk); cfg_rd = 1; cfg_sel = sel; #2 v = cfg_rdata;
        @(negedge clk); cfg_rd = 0;
    endtask

    task automatic peek(input logic [1:0] sel, output logic [DW-1:0] v);
        @(negedge clk); cfg_sel = sel; #2 v = cfg_rdata;
    endtask

    task automatic wait_irq(input string req);
        int n = 0;
        while (irq !== 1'b1 && n < 500) begin @(negedge clk); #2; n++; end
        cmp(req, "irq reached", irq, 1'b1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [DW-1:0] v;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: reset state
        peek(2'd0, v); cmp("R1", "status after reset", v, 0);
        peek(2'd2, v); cmp("R1", "addr after reset", v, 0);
        peek(2'd3, v); cmp("R1", "count after reset", v, 0);
        cmp("R1", "irq after reset", irq, 0);
        cmp("R1", "bus_req after reset", bus_req, 0);

        // R2, R12: program registers
        wr(2'd1, 16'h0005); wr(2'd2, 16'h0020); wr(2'd3, 16'h0004);
        peek(2'd1, v); cmp("R2", "dev readback", v, 5);
        peek(2'd2, v); cmp("R2", "addr readback", v, 16'h20);
        peek(2'd3, v); cmp("R2", "count readback", v, 4);
        cmp("R12", "dev_id pin", dev_id, 4'd5);

        // Input transfer, device always ready, grant after two cycles
        rdy_mode = 1; gnt_lat = 2; gnt_spur = 0;
        wr(2'd0, 16'h0001);
        wait_irq("R8");
        for (int i = 0; i < 4; i++) cmp("R6", "memory word", mem[8'h20 + i], 16'hA000 + i);
        peek(2'd2, v); cmp("R7", "final addr", v, 16'h24);
        peek(2'd3, v); cmp("R7", "final count", v, 0);
        peek(2'd0, v); cmp("R8", "status done not busy", v, 16'h4);
        repeat (5) @(negedge clk);
        cmp("R10", "irq held", irq, 1);
        rd(2'd0, v); #2;
        cmp("R10", "irq cleared by status read", irq, 0);

        // Output transfer, sparse ready, immediate grant, spurious idle grant
        rdy_mode = 3; gnt_lat = 0; gnt_spur = 1;
        wr(2'd2, 16'h0040); wr(2'd3, 16'h0003); wr(2'd0, 16'h0003);
        wait_irq("R8");
        cmp("R6", "words sent to device", dev_got.size(), 3);
        for (int i = 0; i < 3 && i < dev_got.size(); i++)
            cmp("R6", "device word", dev_got[i], DW'((16'h40 + i) * 3 + 7));
        gnt_spur = 0;

        // Zero count completes at once
        wr(2'd0, 16'h0000);
        rd(2'd0, v);
        wr(2'd3, 16'h0000);
        @(negedge clk); cfg_wr = 1; cfg_sel = 2'd0; cfg_wdata = 16'h0001;
        @(negedge clk); cfg_wr = 0; #2;
        cmp("R9", "irq after zero-count start", irq, 1);
        cmp("R9", "no bus request", bus_req, 0);

        // Busy lock and start clearing irq
        rdy_mode = 0; gnt_lat = 1;
        wr(2'd2, 16'h0060); wr(2'd3, 16'h0002); wr(2'd0, 16'h0001);
        #2; cmp("R10", "irq cleared by start", irq, 0);
        wr(2'd2, 16'h0099); wr(2'd3, 16'h0007); wr(2'd1, 16'h0009); wr(2'd0, 16'h0003);
        peek(2'd2, v); cmp("R11", "addr locked", v, 16'h60);
        peek(2'd3, v); cmp("R11", "count locked", v, 2);
        peek(2'd1, v); cmp("R11", "dev locked", v, 5);
        peek(2'd0, v); cmp("R11", "dir kept, busy", v, 16'h1);
        cmp("R3", "no request without ready", bus_req, 0);
        rdy_mode = 1;
        wait_irq("R8");
        cmp("R6", "locked run word 0", mem[8'h60], 16'hA004);
        cmp("R6", "locked run word 1", mem[8'h61], 16'hA005);
        repeat (4) @(negedge clk);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule